// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Monitor

This block sits beside the target-side serial protocol engine and measures how long each low phase of the bus clock lasts. Both bus lines are brought into the clock domain through two-flop synchronizers, and a prescaler turns the core clock into a coarse time tick. A saturating counter counts ticks while the clock line stays low and is cleared whenever the line is high. When the count crosses a parameterised limit and the feature is enabled, the block emits a single-cycle timeout pulse. The protocol engine uses this pulse to clear its transfer state. At the same time the block raises a bus-release level, which tells the engine to stop driving both lines so that they float high.

The bus-release level holds until the synchronized lines show a START (data falls while the clock is high) or a STOP (data rises while the clock is high). After that the engine takes part in the next transaction as normal. A disable input, active high, turns the abort off. A stretched clock then causes no pulse and no release, and the engine simply carries on from where the clock stopped. With the default limit of 30 ticks and a tick programmed to about 1 ms, the abort happens after roughly 30 ms of continuous clock-low time.

Top module: `smbus_lowto_mon`

## Requirements
- R1: Out of reset, timeout_o and bus_release_o are both 0.
- R2: With to_dis_i = 0, if scl_i is held low for n clock cycles where n >= LIMIT_TICKS*(tick_div_i+1), timeout_o goes high for exactly one cycle, 2+LIMIT_TICKS*(tick_div_i+1) rising edges after the first edge that samples scl_i low.
- R3: If scl_i is held low for fewer than LIMIT_TICKS*(tick_div_i+1) cycles, no timeout pulse is produced.
- R4: Every high period of the synchronized clock, even a single cycle long, restarts the low-time measurement from zero.
- R5: A single low phase produces at most one timeout pulse, no matter how long it lasts.
- R6: bus_release_o rises together with the timeout pulse. It stays high while the clock toggles and while data changes with the clock low. It falls only after a START (SDA 1->0 while SCL is 1) or a STOP (SDA 0->1 while SCL is 1).
- R7: With to_dis_i = 1, no clock-low length produces a timeout pulse or raises bus_release_o.
- R8: The low-time counter advances once for every tick_div_i+1 cycles of continuous low clock, so the trip point scales linearly with tick_div_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| to_dis_i | input | 1 | 1 disables the timeout abort; 0 (default use) enables it |
| tick_div_i | input | DIV_W | Tick period minus one, in core clock cycles |
| timeout_o | output | 1 | One-cycle pulse that resets the protocol engine |
| bus_release_o | output | 1 | High while the engine must leave both lines undriven |

## Verification
On every cycle the assertions check the following: the timeout pulse is a single cycle wide, it only follows a low clock, it never appears while the disable input is set, the low-time counter steps by at most one and is cleared by a high clock, and the release level can only rise with a pulse and only fall while the clock is high. The exact trip cycle for each prescaler setting needs the bench's scenarios, as do the absence of a trip just below the limit, the restart after a one-cycle high clock, and the release surviving data activity until a real START or STOP. The bench sweeps the low length around the threshold for every small prescaler value, with the feature both enabled and disabled.

// File: rtl/smbus_to_pkg.sv
package smbus_to_pkg;
  typedef struct packed {
    logic scl;
    logic sda;
  } bus_lines_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/smbus_sync2.sv
module smbus_sync2 #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned STAGES = smbus_to_pkg::SYNC_STAGES;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    // idle bus level is high; reset there to avoid a false edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/smbus_tick_pre.sv
module smbus_tick_pre #(
  parameter int unsigned DIV_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;
  logic             wrap;

  assign wrap   = (pre_q == div_i);
  assign tick_o = run_i && wrap;

  // phase restarts with each low phase so the trip point is exact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else if (wrap)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // R8
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && pre_q != '0) |-> (pre_q == $past(pre_q) + 1'b1));
endmodule

// File: rtl/smbus_low_timer.sv
module smbus_low_timer #(
  parameter int unsigned LIMIT_TICKS = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_lo_i,
  input  logic tick_i,
  input  logic arm_i,
  output logic fire_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(LIMIT_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT_TICKS - 1);

  logic [CNT_W-1:0] lo_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           lo_cnt_q <= '0;
    else if (!scl_lo_i)                    lo_cnt_q <= '0;
    else if (tick_i && lo_cnt_q != CNT_TOP) lo_cnt_q <= lo_cnt_q + 1'b1;
  end

  // crossing only: saturation at CNT_TOP keeps it to one fire per phase
  assign fire_o = scl_lo_i && tick_i && arm_i && (lo_cnt_q == CNT_LAST);

  // R4
  low_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scl_lo_i |=> (lo_cnt_q == '0));
  // R8
  low_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_cnt_q != $past(lo_cnt_q)) |-> (lo_cnt_q == '0 || lo_cnt_q == $past(lo_cnt_q) + 1'b1));
  // R5
  low_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_cnt_q <= CNT_TOP);
endmodule

// File: rtl/smbus_rel_ctl.sv
module smbus_rel_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic set_i,
  output logic rel_o
);
  logic sda_q, rel_q, start_c, stop_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_q <= 1'b1;
    else         sda_q <= sda_s_i;
  end

  assign start_c = scl_s_i &&  sda_q && !sda_s_i;
  assign stop_c  = scl_s_i && !sda_q &&  sda_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rel_q <= 1'b0;
    else if (set_i)            rel_q <= 1'b1;
    else if (start_c || stop_c) rel_q <= 1'b0;
  end

  assign rel_o = rel_q;

  // R6
  rel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rel_q) |-> $past(scl_s_i));
  // R6
  rel_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rel_q) |-> $past(!scl_s_i));
endmodule

// File: rtl/smbus_lowto_mon.sv
module smbus_lowto_mon #(
  parameter int unsigned LIMIT_TICKS = 30,
  parameter int unsigned DIV_W       = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             to_dis_i,
  input  logic [DIV_W-1:0] tick_div_i,
  output logic             timeout_o,
  output logic             bus_release_o
);
  import smbus_to_pkg::*;

  bus_lines_t raw, syn;
  logic tick, fire, timeout_q;

  assign raw.scl = scl_i;
  assign raw.sda = sda_i;

  smbus_sync2 #(.W($bits(bus_lines_t))) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  smbus_tick_pre #(.DIV_W(DIV_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (!syn.scl),
    .div_i (tick_div_i),
    .tick_o(tick)
  );

  smbus_low_timer #(.LIMIT_TICKS(LIMIT_TICKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_lo_i(!syn.scl),
    .tick_i  (tick),
    .arm_i   (!to_dis_i),
    .fire_o  (fire)
  );

  smbus_rel_ctl u_rel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_s_i(syn.scl),
    .sda_s_i(syn.sda),
    .set_i  (fire),
    .rel_o  (bus_release_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timeout_q <= 1'b0;
    else         timeout_q <= fire;
  end

  assign timeout_o = timeout_q;

  // R2
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  // R2
  pulse_after_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $past(!syn.scl));
  // R7
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(to_dis_i) |-> !timeout_o);
  // R6
  rel_with_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_release_o) |-> timeout_o);
endmodule

// File: tb/tb_smbus_lowto_mon.sv
`timescale 1ns/1ps
module tb_smbus_lowto_mon;
  localparam int unsigned LIM = 4;
  localparam int unsigned DW  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, dis = 1'b0;
  logic [DW-1:0] div = '0;
  logic to_p, rel;
  int total = 0, bad = 0;
  bit exp_rel = 1'b0;

  always #2 clk = ~clk;

  smbus_lowto_mon #(.LIMIT_TICKS(LIM), .DIV_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .to_dis_i(dis), .tick_div_i(div), .timeout_o(to_p), .bus_release_o(rel)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // low phase of n cycles, then 6 high cycles; tally pulses
  task automatic low_phase(int n, int d, bit dz);
    int pulses = 0, idx = -1, thr;
    bit fire;
    thr = LIM * (d + 1);
    fire = !dz && (n >= thr);
    @(negedge clk);
    div = DW'(d); dis = dz;
    @(negedge clk);
    scl = 1'b0;
    for (int m = 1; m <= n + 6; m++) begin
      @(negedge clk);
      if (to_p) begin pulses++; if (idx < 0) idx = m; end
      if (m == n) scl = 1'b1;
    end
    if (dz)
      chk(pulses == 0, "R7", "pulses with disable", pulses, 0);
    else if (fire) begin
      chk(pulses == 1, "R5", "pulse count over limit", pulses, 1);
      chk(idx == thr + 2, "R2", "trip cycle", idx, thr + 2);
    end else
      chk(pulses == 0, "R3", "pulses under limit", pulses, 0);
    if (fire) exp_rel = 1'b1;
    chk(rel == exp_rel, dz ? "R7" : "R6", "release level", rel, exp_rel);
  endtask

  task automatic clr_start();
    @(negedge clk); sda = 1'b0;
    repeat (4) @(negedge clk);
    exp_rel = 1'b0;
    chk(rel == 1'b0, "R6", "release after START", rel, 0);
    sda = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic clr_stop();
    @(negedge clk); div = '0; scl = 1'b0;
    @(negedge clk); sda = 1'b0;
    @(negedge clk); scl = 1'b1;
    repeat (4) @(negedge clk);
    chk(rel == exp_rel, "R6", "release through data change", rel, exp_rel);
    sda = 1'b1;
    repeat (4) @(negedge clk);
    exp_rel = 1'b0;
    chk(rel == 1'b0, "R6", "release after STOP", rel, 0);
  endtask

  task automatic run_all();
    int pulses;
    repeat (3) @(negedge clk);
    chk(to_p == 1'b0, "R1", "timeout after reset", to_p, 0);
    chk(rel == 1'b0, "R1", "release after reset", rel, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(to_p == 1'b0 && rel == 1'b0, "R1", "outputs idle", {to_p, rel}, 0);

    // R8 sweep: trip point tracks prescaler setting
    for (int dz = 0; dz < 2; dz++)
      for (int d = 0; d < 4; d++) begin
        for (int n = 1; n <= LIM * (d + 1) + 3; n++) begin
          low_phase(n, d, dz[0]);
          if (exp_rel) begin
            if (n % 2 == 0) clr_start(); else clr_stop();
          end
        end
        low_phase(3 * LIM * (d + 1), d, dz[0]);
        if (exp_rel) clr_start();
      end

    // R4: one-cycle high gap restarts measurement
    @(negedge clk); div = DW'(1); dis = 1'b0;
    pulses = 0;
    @(negedge clk); scl = 1'b0;
    for (int m = 1; m <= 4 * LIM * 2; m++) begin
      @(negedge clk);
      if (to_p) pulses++;
      if (m % (LIM * 2 - 1) == 0) scl = 1'b1;
      else scl = 1'b0;
    end
    scl = 1'b1;
    repeat (6) @(negedge clk) if (to_p) pulses++;
    chk(pulses == 0, "R4", "pulses across short gaps", pulses, 0);
    chk(rel == 1'b0, "R4", "release across short gaps", rel, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R1..R8 actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule